// File: doc/BRIEF.md
# PTP Transmit Timestamp Capture Unit

This block records the system time at the moment a timing message leaves a network channel. Each channel watches a transmit-detect pulse that comes with a decoded message-type code. A channel set as clock master takes a snapshot only for Sync messages. A channel set as clock slave takes a snapshot only for Delay_Req messages. The 64-bit time present on that same clock cycle is latched into a snapshot register for the channel.

Each capture raises a sticky event flag. The flag locks the snapshot until firmware clears it by writing a one. Firmware can therefore read the two 32-bit halves over the register bus in any order and always get a matching pair. A qualifying message that arrives while the snapshot is locked is dropped, and an overrun flag records the loss. An optional per-channel interrupt follows the event flag.

Every channel has its own register window, and the windows are spaced a fixed stride apart. Inside each window:

| Offset | Register | Access |
|---|---|---|
| +0x0 | Snapshot low word | read-only |
| +0x4 | Snapshot high word | read-only |
| +0x8 | Event register | write-one-to-clear |
| +0xC | Interrupt enable, bit 0 | read/write |

Top module: `ptp_txts_capture`

## Requirements
- R1: A master channel (mode bit 1) captures only when the transmit-detect pulse carries message-type code 0x0 (Sync). The codes 0x1 and 0x8 cause no capture.
- R2: A slave channel (mode bit 0) captures only when the transmit-detect pulse carries message-type code 0x1 (Delay_Req). The code 0x0 causes no capture.
- R3: The captured value equals sys_time on the clock cycle of the detect pulse. Bits 31:0 read at offset 0x48+0x20*n for channel n, and bits 63:32 read at that offset plus 4.
- R4: A capture sets the channel's txs flag. The txs flag is bit 0 of the event register at window offset +8. Writing a 1 to that bit clears the flag. Writing 0 leaves it unchanged.
- R5: While txs is set, the snapshot does not change, even when further qualifying messages arrive and sys_time moves.
- R6: A qualifying message that arrives while txs is set, with no clear in the same cycle, sets the sticky overrun bit (event register bit 1). Writing a 1 to bit 1 clears the overrun bit.
- R7: When a txs clear and a qualifying message fall in the same cycle, the capture wins: the new time is latched and txs stays set.
- R8: After reset, both snapshot words, txs, overrun, the interrupt enable and irq are all zero.
- R9: irq is high exactly while txs is set and the interrupt enable (window offset +0xC, bit 0) is 1. The enable reads back at the same offset.
- R10: Channels are independent: a capture or clear on one channel leaves every other channel's snapshot and flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_time | input | 64 | Free-running system time |
| chan_master | input | NUM_CH | Per-channel mode: 1 master, 0 slave |
| tx_det | input | NUM_CH | Per-channel transmit-detect pulse |
| tx_msg_type | input | 4*NUM_CH | Decoded message type, 4 bits per channel |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 2 | Write data (only two writable bits exist) |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| snap_lo | output | 32*NUM_CH | Per-channel snapshot bits 31:0 |
| snap_hi | output | 32*NUM_CH | Per-channel snapshot bits 63:32 |
| txs_flag | output | NUM_CH | Per-channel sticky capture flag |
| irq | output | NUM_CH | Per-channel interrupt |

## Verification
The bench targets four corner cases:

- **Wrong message for the mode.** It sends a Delay_Req on a master channel and a Sync on a slave channel. A decoder that ignored the mode bit would capture on these.
- **Second message while locked.** It sends a second qualifying message with a new time while txs is set. A design without the lock would overwrite the snapshot, and firmware would read a torn pair.
- **Clear and capture together.** It writes the txs clear in the same cycle as a new qualifying message. A design that let the clear win would lose the timestamp.
- **Zero write and channel spacing.** It writes 0 to the event register, which must leave txs set. It then reads the windows of channels 1 and 2, which would expose a wrong stride or a swapped low/high word.

// File: rtl/ptp_txts_pkg.sv
package ptp_txts_pkg;
   localparam int TIME_W   = 64;
   localparam int WORD_W   = 32;
   localparam int MSGT_W   = 4;
   localparam int WDATA_W  = 2;
   // register offsets inside one channel window
   localparam int OFF_LO   = 0;
   localparam int OFF_HI   = 4;
   localparam int OFF_EVT  = 8;
   localparam int OFF_CTL  = 12;
   // event register bit positions
   localparam int EVT_TXS  = 0;
   localparam int EVT_OVR  = 1;
   // message-type codes
   localparam logic [MSGT_W-1:0] MT_SYNC = 4'h0;
   localparam logic [MSGT_W-1:0] MT_DREQ = 4'h1;
endpackage

// File: rtl/ptp_txts_qualify.sv
module ptp_txts_qualify
   import ptp_txts_pkg::*;
#(
   parameter logic [MSGT_W-1:0] SYNC_CODE = MT_SYNC,
   parameter logic [MSGT_W-1:0] DREQ_CODE = MT_DREQ
) (
   input  logic              is_master,
   input  logic              det,
   input  logic [MSGT_W-1:0] mtype,
   output logic              qual
);
   logic [MSGT_W-1:0] want;

   if (SYNC_CODE == DREQ_CODE) begin : g_bad_codes
      $error("ptp_txts_qualify: Sync and Delay_Req codes must differ");
   end

   assign want = is_master ? SYNC_CODE : DREQ_CODE;
   assign qual = det && (mtype == want);
endmodule

// File: rtl/ptp_txts_channel.sv
module ptp_txts_channel
   import ptp_txts_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [TIME_W-1:0]  sys_time,
   input  logic               qual,
   input  logic               wr_evt,
   input  logic               wr_ctl,
   input  logic [WDATA_W-1:0] wdata,
   output logic [TIME_W-1:0]  snap,
   output logic               txs,
   output logic               ovr,
   output logic               ien,
   output logic               irq
);
   logic clr_txs, clr_ovr, take, drop;

   assign clr_txs = wr_evt && wdata[EVT_TXS];
   assign clr_ovr = wr_evt && wdata[EVT_OVR];
   // a clear in the same cycle frees the lock, so the capture wins
   assign take    = qual && (!txs || clr_txs);
   assign drop    = qual && txs && !clr_txs;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         snap <= '0;
         txs  <= 1'b0;
         ovr  <= 1'b0;
         ien  <= 1'b0;
      end else begin
         if (take) snap <= sys_time;
         txs <= take || (txs && !clr_txs);
         ovr <= drop || (ovr && !clr_ovr);
         if (wr_ctl) ien <= wdata[0];
      end
   end

   assign irq = txs && ien;

   // R5: a locked snapshot holds its value
   p_locked_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (txs && !clr_txs) |=> $stable(snap));
   // R3: capture samples time on the pulse cycle
   p_capture_time_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (qual && !txs) |=> (txs && snap == $past(sys_time)));
   // R4: a write without bit 0 leaves txs set
   p_txs_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (txs && !clr_txs) |=> txs);
   // R6: a dropped event leaves overrun set
   p_overrun_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (qual && txs && !clr_txs) |=> ovr);
   // R7: clear and capture in one cycle keeps txs
   p_capture_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (qual && clr_txs) |=> (txs && snap == $past(sys_time)));
   // R9: no interrupt without a pending snapshot
   p_irq_needs_txs_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !txs |-> !irq);
endmodule

// File: rtl/ptp_txts_capture.sv
module ptp_txts_capture
   import ptp_txts_pkg::*;
#(
   parameter int NUM_CH    = 3,
   parameter int ADDR_W    = 8,
   parameter int LO_BASE   = 'h48,
   parameter int CH_STRIDE = 'h20
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [TIME_W-1:0]        sys_time,
   input  logic [NUM_CH-1:0]        chan_master,
   input  logic [NUM_CH-1:0]        tx_det,
   input  logic [NUM_CH*MSGT_W-1:0] tx_msg_type,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic                     bus_wr,
   input  logic [WDATA_W-1:0]       bus_wdata,
   output logic [WORD_W-1:0]        bus_rdata,
   output logic [NUM_CH*WORD_W-1:0] snap_lo,
   output logic [NUM_CH*WORD_W-1:0] snap_hi,
   output logic [NUM_CH-1:0]        txs_flag,
   output logic [NUM_CH-1:0]        irq
);
   localparam int LAST_ADDR = LO_BASE + (NUM_CH - 1) * CH_STRIDE + OFF_CTL;

   if (NUM_CH < 1) begin : g_bad_nch
      $error("ptp_txts_capture: NUM_CH must be at least 1");
   end
   if (CH_STRIDE < OFF_CTL + 4) begin : g_bad_stride
      $error("ptp_txts_capture: channel windows overlap");
   end
   if (LAST_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("ptp_txts_capture: ADDR_W too narrow for the register windows");
   end

   logic [ADDR_W-1:0] ch_base [NUM_CH];
   logic [TIME_W-1:0] ch_snap [NUM_CH];
   logic [NUM_CH-1:0] ch_ovr, ch_ien;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic qual, wr_evt, wr_ctl;

      assign ch_base[c] = ADDR_W'(LO_BASE + c * CH_STRIDE);
      assign wr_evt = bus_wr && (bus_addr == ch_base[c] + ADDR_W'(OFF_EVT));
      assign wr_ctl = bus_wr && (bus_addr == ch_base[c] + ADDR_W'(OFF_CTL));

      ptp_txts_qualify u_qual (
         .is_master (chan_master[c]),
         .det       (tx_det[c]),
         .mtype     (tx_msg_type[c*MSGT_W +: MSGT_W]),
         .qual      (qual)
      );

      ptp_txts_channel u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .sys_time (sys_time),
         .qual     (qual),
         .wr_evt   (wr_evt),
         .wr_ctl   (wr_ctl),
         .wdata    (bus_wdata),
         .snap     (ch_snap[c]),
         .txs      (txs_flag[c]),
         .ovr      (ch_ovr[c]),
         .ien      (ch_ien[c]),
         .irq      (irq[c])
      );

      assign snap_lo[c*WORD_W +: WORD_W] = ch_snap[c][WORD_W-1:0];
      assign snap_hi[c*WORD_W +: WORD_W] = ch_snap[c][TIME_W-1:WORD_W];
   end

   always_comb begin
      bus_rdata = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (bus_addr == ch_base[c] + ADDR_W'(OFF_LO))
            bus_rdata = ch_snap[c][WORD_W-1:0];
         else if (bus_addr == ch_base[c] + ADDR_W'(OFF_HI))
            bus_rdata = ch_snap[c][TIME_W-1:WORD_W];
         else if (bus_addr == ch_base[c] + ADDR_W'(OFF_EVT))
            bus_rdata = {{(WORD_W-2){1'b0}}, ch_ovr[c], txs_flag[c]};
         else if (bus_addr == ch_base[c] + ADDR_W'(OFF_CTL))
            bus_rdata = {{(WORD_W-1){1'b0}}, ch_ien[c]};
      end
   end

   // R8: flags come out of reset clear
   p_reset_clear_r8: assert property (@(posedge clk)
      !rst_n |=> (txs_flag == '0 && irq == '0));
endmodule

// File: tb/ptp_txts_capture_tb.sv
module ptp_txts_capture_tb_top;
   localparam int CLK_P = 10;
   localparam int NCH   = 3;

   typedef struct packed {
      logic        master;
      logic        det;
      logic [3:0]  typ;
      logic        wr;
      logic [1:0]  wm;
      logic [63:0] tm;
      logic        e_txs;
      logic        e_ovr;
      logic [63:0] e_snap;
   } vec_t;

   localparam logic [63:0] TA = 64'h0000_0001_0000_0010;
   localparam logic [63:0] TE = 64'hDEAD_BEEF_0123_4567;
   localparam logic [63:0] TF = 64'hCAFE_F00D_89AB_CDEF;
   localparam int NV = 11;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 1'b1, 4'h0, 1'b0, 2'b00, TA,                    1'b1, 1'b0, TA}, // R1 Sync master
      '{1'b1, 1'b1, 4'h0, 1'b0, 2'b00, 64'h0000_0002_0000_0020, 1'b1, 1'b1, TA}, // R5 R6 locked
      '{1'b1, 1'b0, 4'h0, 1'b1, 2'b01, 64'h5,                 1'b0, 1'b1, TA}, // R4 clear txs
      '{1'b1, 1'b1, 4'h1, 1'b0, 2'b00, 64'h0000_0003_0000_0030, 1'b0, 1'b1, TA}, // R1 DREQ on master
      '{1'b0, 1'b1, 4'h0, 1'b0, 2'b00, 64'h0000_0004_0000_0040, 1'b0, 1'b1, TA}, // R2 Sync on slave
      '{1'b0, 1'b1, 4'h1, 1'b0, 2'b00, TE,                    1'b1, 1'b1, TE}, // R2 DREQ slave
      '{1'b0, 1'b1, 4'h1, 1'b1, 2'b01, TF,                    1'b1, 1'b1, TF}, // R7 capture wins
      '{1'b0, 1'b0, 4'h0, 1'b1, 2'b10, 64'h0,                 1'b1, 1'b0, TF}, // R6 clear ovr
      '{1'b0, 1'b0, 4'h0, 1'b1, 2'b00, 64'h0,                 1'b1, 1'b0, TF}, // R4 write zero
      '{1'b0, 1'b0, 4'h0, 1'b1, 2'b01, 64'h0,                 1'b0, 1'b0, TF}, // R4 clear
      '{1'b1, 1'b1, 4'h8, 1'b0, 2'b00, 64'h0000_0009_0000_0090, 1'b0, 1'b0, TF}  // R1 other code
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [63:0]       sys_time = '0;
   logic [NCH-1:0]    chan_master = '0;
   logic [NCH-1:0]    tx_det = '0;
   logic [NCH*4-1:0]  tx_msg_type = '0;
   logic [7:0]        bus_addr = '0;
   logic              bus_wr = 1'b0;
   logic [1:0]        bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic [NCH*32-1:0] snap_lo, snap_hi;
   logic [NCH-1:0]    txs_flag, irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   ptp_txts_capture dut_i (
      .clk(clk), .rst_n(rst_n), .sys_time(sys_time), .chan_master(chan_master),
      .tx_det(tx_det), .tx_msg_type(tx_msg_type), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .snap_lo(snap_lo), .snap_hi(snap_hi), .txs_flag(txs_flag), .irq(irq)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      bus_wr   = 1'b0;
      #1 d = bus_rdata;
   endtask

   // one clock with bus write; caller already set time/events; ends at negedge
   task automatic cyc_wr(input logic [7:0] a, input logic wr, input logic [1:0] wd);
      bus_addr = a; bus_wr = wr; bus_wdata = wd;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0; tx_det = '0;
   endtask

   task automatic send(input int ch, input logic m, input logic [3:0] t, input logic [63:0] tm);
      chan_master[ch] = m;
      tx_det[ch] = 1'b1;
      tx_msg_type[ch*4 +: 4] = t;
      sys_time = tm;
      cyc_wr(8'h00, 1'b0, 2'b00);
   endtask

   initial begin
      logic [31:0] d, d2;
      @(negedge clk); @(negedge clk);
      // R8 reset state, checked while reset is still asserted
      chk("R8 snap_lo", 64'(snap_lo), 64'h0);
      chk("R8 snap_hi", 64'(snap_hi), 64'h0);
      chk("R8 txs", 64'(txs_flag), 64'h0);
      chk("R8 irq", 64'(irq), 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      rd(8'h48, d); chk("R8 read lo", 64'(d), 64'h0);
      rd(8'h4C, d); chk("R8 read hi", 64'(d), 64'h0);
      rd(8'h54, d); chk("R8 enable", 64'(d), 64'h0);

      // vector table on channel 0
      for (int i = 0; i < NV; i++) begin
         chan_master[0] = VEC[i].master;
         tx_det[0] = VEC[i].det;
         tx_msg_type[3:0] = VEC[i].typ;
         sys_time = VEC[i].tm;
         cyc_wr(8'h50, VEC[i].wr, VEC[i].wm);
         chk($sformatf("R1/R2 R4 txs step %0d", i), 64'(txs_flag[0]), 64'(VEC[i].e_txs));
         chk($sformatf("R3 R5 R7 snap step %0d", i), {snap_hi[31:0], snap_lo[31:0]}, VEC[i].e_snap);
         rd(8'h50, d);
         chk($sformatf("R6 ovr step %0d", i), 64'(d[1]), 64'(VEC[i].e_ovr));
      end
      // channels 1 and 2 untouched by channel 0 activity (R10)
      chk("R10 ch1/ch2 snap", {snap_hi[95:32], snap_lo[95:32]}, 128'h0);
      chk("R10 ch1/ch2 txs", 64'(txs_flag[2:1]), 64'h0);

      // R9 interrupt enable
      sys_time = '0;
      cyc_wr(8'h54, 1'b1, 2'b01);
      rd(8'h54, d); chk("R9 enable readback", 64'(d), 64'h1);
      chk("R9 irq idle", 64'(irq[0]), 64'h0);
      send(0, 1'b1, 4'h0, 64'h77);
      chk("R9 irq raised", 64'(irq), 64'h1);
      cyc_wr(8'h50, 1'b1, 2'b01);
      chk("R9 irq dropped", 64'(irq[0]), 64'h0);

      // R3 R10 channel 1 window (slave Delay_Req)
      send(1, 1'b0, 4'h1, 64'h1111_2222_3333_4444);
      rd(8'h68, d); chk("R3 ch1 lo", 64'(d), 64'h3333_4444);
      rd(8'h6C, d); chk("R3 ch1 hi", 64'(d), 64'h1111_2222);
      chk("R10 ch2 idle", 64'(txs_flag[2]), 64'h0);
      chk("R10 ch0 idle", 64'(txs_flag[0]), 64'h0);
      chk("R10 irq ch1 masked", 64'(irq), 64'h0);

      // R3 channel 2 window, then R5 coherence under new events
      send(2, 1'b1, 4'h0, 64'h5555_6666_7777_8888);
      send(2, 1'b1, 4'h0, 64'hFFFF_FFFF_FFFF_FFFF);
      sys_time = 64'h0123_0000_0000_0000;
      rd(8'h8C, d);
      send(2, 1'b1, 4'h0, 64'h0000_0000_0000_0001);
      rd(8'h88, d2);
      chk("R5 coherent hi", 64'(d), 64'h5555_6666);
      chk("R5 coherent lo", 64'(d2), 64'h7777_8888);
      rd(8'h90, d); chk("R6 ch2 overrun", 64'(d), 64'h3);
      rd(8'h68, d); chk("R10 ch1 kept", 64'(d), 64'h3333_4444);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_P * 20000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule